// File: doc/BRIEF.md
# Masked packed integer-to-double converter

This block turns up to eight signed 32-bit integers into IEEE-754 double-precision values and assembles them into a destination vector of up to 512 bits. Each lane converts exactly, because every 32-bit integer fits in a double. The conversion finds the magnitude and the position of its highest set bit, derives the biased exponent from that position, and left-aligns the remaining bits into the 52-bit fraction.

Around the conversion sit the rules for writing the destination. A per-lane write mask selects which lanes are written, and a masked-off lane either merges, keeping its old value, or is zeroed. A broadcast option feeds one scalar to every lane. A vector-length code sets how many lanes are active. An encoding-mode code decides what happens to the bits above the active length: they are zeroed, or they keep the old destination contents. A malformed register-specifier field raises an undefined-opcode flag, and the destination then keeps its old value. The caller supplies operands that have already been read, together with the old destination. One cycle later the registered result appears with `out_valid`.

Top module: `int2dbl_vec_cvt`

## Requirements
- R1: Each written lane holds the exact IEEE-754 double of its signed 32-bit source. Zero gives 64'h0, and -2^31 gives 64'hC1E0000000000000.
- R2: Lane i reads `src[32i+31:32i]` and writes `dst[64i+63:64i]`. In wide mode (`enc_mode`=2), `vl_sel` 0 activates 2 lanes, 1 activates 4 lanes, and 2 or 3 activates 8 lanes.
- R3: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid`=1. `dst` and `ud` keep their values while `in_valid` is 0.
- R4: In wide mode with `mask_en`=1, active lane i is converted only when `mask[i]`=1. Otherwise the lane keeps its `old_dst` value when `zero_en`=0, or becomes zero when `zero_en`=1. With `mask_en`=0, every active lane is converted.
- R5: In wide mode with `bcst_en`=1, `bcst_val` is the source of every lane and `src` is not used.
- R6: In wide mode, every destination bit above the active length is zero.
- R7: In short mode (`enc_mode`=1), `vl_sel`=0 activates 2 lanes and any other value activates 4 lanes. Bits above the active length are zeroed. `mask`, `mask_en`, `zero_en` and `bcst_en` have no effect.
- R8: In legacy mode (`enc_mode`=0), 2 lanes are always active. `dst[511:128]` keeps `old_dst[511:128]`. `vl_sel`, `mask`, `mask_en`, `zero_en` and `bcst_en` have no effect.
- R9: `rc_req` has no effect on any output.
- R10: When `vvvv` is not 4'b1111, or when `enc_mode` is 3, `ud` is 1 and `dst` equals `old_dst`. Otherwise `ud` is 0.
- R11: After reset, `out_valid`, `ud` and `dst` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| src | input | 256 | Packed signed 32-bit source elements |
| bcst_val | input | 32 | Broadcast scalar |
| bcst_en | input | 1 | Use the broadcast scalar for all lanes |
| mask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | Apply the write mask |
| zero_en | input | 1 | 1: masked-off lanes are zeroed; 0: they merge |
| vl_sel | input | 2 | Vector-length code |
| enc_mode | input | 2 | 0 legacy, 1 short, 2 wide, 3 invalid |
| rc_req | input | 2 | Requested rounding control (ignored) |
| vvvv | input | 4 | Extra register-specifier field, must be 4'b1111 |
| old_dst | input | 512 | Previous destination contents |
| out_valid | output | 1 | Result valid |
| dst | output | 512 | New destination value |
| ud | output | 1 | Undefined-opcode flag |

## Verification
The bench builds the block with its default maximum vector length of 512 bits, so lane counts of 2, 4 and 8 are all reachable. Every encoding mode can then be shown against a full 512-bit old destination, so the merged, zeroed and preserved regions above 128 and above 256 bits are all visible at the ports. Expected lane values come from the simulator's own integer-to-real conversion. This covers the extreme magnitudes, the most negative input, and zero.

// File: rtl/int2dbl_vec_cvt.sv
module int2dbl_vec_cvt #(
  parameter int MAXVL = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [MAXVL/2-1:0] src,
  input  logic [31:0]        bcst_val,
  input  logic               bcst_en,
  input  logic [MAXVL/64-1:0] mask,
  input  logic               mask_en,
  input  logic               zero_en,
  input  logic [1:0]         vl_sel,
  input  logic [1:0]         enc_mode,
  input  logic [1:0]         rc_req,
  input  logic [3:0]         vvvv,
  input  logic [MAXVL-1:0]   old_dst,
  output logic               out_valid,
  output logic [MAXVL-1:0]   dst,
  output logic               ud
);
  localparam int LANES = MAXVL / 64;

  function automatic logic [63:0] i2d(input logic [31:0] v);
    logic [31:0] mag, sh;
    logic [4:0]  msb;
    mag = v[31] ? (~v + 32'd1) : v;
    msb = 5'd0;
    for (int b = 0; b < 32; b++)
      if (mag[b]) msb = 5'(b);
    sh = mag << (5'd31 - msb);
    if (mag == 32'd0) return 64'd0;
    return {v[31], 11'd1023 + {6'd0, msb}, sh[30:0], 21'd0};
  endfunction

  logic [3:0] act;
  always_comb begin
    case (enc_mode)
      2'd0:    act = 4'd2;
      2'd1:    act = (vl_sel == 2'd0) ? 4'd2 : 4'd4;
      default: act = (vl_sel == 2'd0) ? 4'd2 : (vl_sel == 2'd1) ? 4'd4 : 4'd8;
    endcase
  end

  wire bad      = (vvvv != 4'hF) || (enc_mode == 2'd3);
  wire use_mask = (enc_mode == 2'd2) && mask_en;
  wire use_bc   = (enc_mode == 2'd2) && bcst_en;
  logic [MAXVL-1:0] nxt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wire [31:0] s   = use_bc ? bcst_val : src[32*i +: 32];
    wire        on  = (4'(i) < act);
    wire        wr  = !use_mask || mask[i];
    wire [63:0] old = old_dst[64*i +: 64];
    assign nxt[64*i +: 64] = !on ? ((enc_mode == 2'd0) ? old : 64'd0)
                           : wr  ? i2d(s)
                           : (zero_en ? 64'd0 : old);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
      ud        <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ud  <= bad;
        dst <= bad ? old_dst : nxt;
      end
    end
  end

  assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(dst) && $stable(ud));
  assert_ud_keeps_old_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && vvvv != 4'hF |=> ud && dst == $past(old_dst));
  assert_legacy_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && enc_mode == 2'd0 && vvvv == 4'hF |=>
      dst[MAXVL-1:128] == $past(old_dst[MAXVL-1:128]));
  assert_short_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && enc_mode == 2'd1 && vvvv == 4'hF |=> dst[MAXVL-1:256] == '0);
  assert_zero_lane0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && enc_mode == 2'd2 && mask_en && zero_en && !mask[0] && vvvv == 4'hF
      |=> dst[63:0] == 64'd0);
  assert_rc_no_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && rc_req != 2'd0 && vvvv == 4'hF && enc_mode != 2'd3 |=> !ud);
endmodule

// File: tb/int2dbl_vec_cvt_tb_top.sv
module int2dbl_vec_cvt_tb_top;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [255:0] src = '0;
  logic [31:0] bcst_val = '0;
  logic bcst_en = 0, mask_en = 0, zero_en = 0;
  logic [7:0] mask = '0;
  logic [1:0] vl_sel = '0, enc_mode = '0, rc_req = '0;
  logic [3:0] vvvv = 4'hF;
  logic [511:0] old_dst = '0;
  logic out_valid, ud;
  logic [511:0] dst;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  int2dbl_vec_cvt dut_i (.clk, .rst_n, .in_valid, .src, .bcst_val, .bcst_en, .mask,
    .mask_en, .zero_en, .vl_sel, .enc_mode, .rc_req, .vvvv, .old_dst, .out_valid, .dst, .ud);

  function automatic logic [63:0] ref_d(input logic [31:0] v);
    return $realtobits($itor($signed(v)));
  endfunction

  function automatic logic [511:0] old_pat(input logic [15:0] tag);
    logic [511:0] r;
    for (int i = 0; i < 8; i++) r[64*i +: 64] = {tag, 16'hBEEF, 24'h0, 8'(i)};
    return r;
  endfunction

  function automatic logic [255:0] pack(input int a0, a1, a2, a3, a4, a5, a6, a7);
    return {a7, a6, a5, a4, a3, a2, a1, a0};
  endfunction

  function automatic logic [511:0] model(input logic [255:0] s, input logic [31:0] b,
      input logic be, input logic [7:0] m, input logic me, ze, input logic [1:0] vl, enc,
      input logic [3:0] vv, input logic [511:0] od);
    logic [511:0] r;
    int n;
    if (vv != 4'hF || enc == 2'd3) return od;
    n = (enc == 0) ? 2 : (vl == 0) ? 2 : (enc == 1 || vl == 1) ? 4 : 8;
    for (int i = 0; i < 8; i++) begin
      if (i >= n) r[64*i +: 64] = (enc == 0) ? od[64*i +: 64] : 64'd0;
      else if (enc == 2 && me && !m[i]) r[64*i +: 64] = ze ? 64'd0 : od[64*i +: 64];
      else r[64*i +: 64] = ref_d((enc == 2 && be) ? b : s[32*i +: 32]);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [511:0] act, exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [255:0] s, input logic [31:0] b,
      input logic be, input logic [7:0] m, input logic me, ze, input logic [1:0] vl, enc, rc,
      input logic [3:0] vv, input logic [511:0] od);
    logic [511:0] e, held;
    e = model(s, b, be, m, me, ze, vl, enc, vv, od);
    src = s; bcst_val = b; bcst_en = be; mask = m; mask_en = me; zero_en = ze;
    vl_sel = vl; enc_mode = enc; rc_req = rc; vvvv = vv; old_dst = od; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk({req, " R3 valid"}, {511'd0, out_valid}, 512'd1);
    chk({req, " dst"}, dst, e);
    chk({req, " R10 ud"}, {511'd0, ud}, {511'd0, (vv != 4'hF || enc == 2'd3)});
    held = dst;
    src = ~s; old_dst = ~od;
    @(negedge clk);
    chk({req, " R3 idle hold"}, {out_valid, dst[510:0]}, {1'b0, held[510:0]});
  endtask

  task automatic t_reset;
    chk("R11 reset", {dst[509:0], out_valid, ud}, 512'd0);
  endtask

  task automatic t_corners;
    logic [255:0] s;
    s = pack(0, 1, -1, 32'h7FFFFFFF, 32'h80000000, 3, 12345, -1000);
    run("R1 R2 wide512", s, 0, 0, 8'h00, 0, 0, 2'd2, 2'd2, 0, 4'hF, old_pat(16'h1111));
    run("R1 R2 wide512 vl3", s, 0, 0, 8'h00, 0, 0, 2'd3, 2'd2, 0, 4'hF, old_pat(16'h1112));
    src = s; old_dst = old_pat(16'h1111); vl_sel = 2'd2; enc_mode = 2'd2; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R1 zero lane", {448'd0, dst[63:0]}, 512'd0);
    chk("R1 min int lane", {448'd0, dst[319:256]}, {448'd0, 64'hC1E0000000000000});
    chk("R1 minus one lane", {448'd0, dst[191:128]}, {448'd0, 64'hBFF0000000000000});
  endtask

  task automatic t_masks;
    logic [255:0] s;
    s = pack(7, -7, 100, -100, 65536, -65536, 42, -42);
    run("R4 R6 merge 256", s, 0, 0, 8'b1010_0101, 1, 0, 2'd1, 2'd2, 0, 4'hF, old_pat(16'h2222));
    run("R4 R6 zero 128", s, 0, 0, 8'b1111_1110, 1, 1, 2'd0, 2'd2, 0, 4'hF, old_pat(16'h2223));
    run("R4 zero 512", s, 0, 0, 8'b0110_1001, 1, 1, 2'd2, 2'd2, 0, 4'hF, old_pat(16'h2224));
    run("R4 mask off", s, 0, 0, 8'h00, 0, 1, 2'd2, 2'd2, 0, 4'hF, old_pat(16'h2225));
  endtask

  task automatic t_bcst;
    run("R5 bcst 512", pack(1, 2, 3, 4, 5, 6, 7, 8), -123456, 1, 8'h00, 0, 0, 2'd2, 2'd2, 0,
        4'hF, old_pat(16'h3333));
    run("R5 bcst masked", pack(1, 2, 3, 4, 5, 6, 7, 8), 32'h80000000, 1, 8'h0F, 1, 0, 2'd2,
        2'd2, 0, 4'hF, old_pat(16'h3334));
  endtask

  task automatic t_short;
    run("R7 short 128", pack(9, -9, 1, 1, 1, 1, 1, 1), 55, 1, 8'h00, 1, 1, 2'd0, 2'd1, 0,
        4'hF, old_pat(16'h4444));
    run("R7 short 256", pack(9, -9, 5, -5, 1, 1, 1, 1), 55, 1, 8'h00, 1, 1, 2'd2, 2'd1, 0,
        4'hF, old_pat(16'h4445));
  endtask

  task automatic t_legacy;
    run("R8 legacy", pack(-2, 2, 3, 3, 3, 3, 3, 3), 77, 1, 8'h00, 1, 1, 2'd2, 2'd0, 0,
        4'hF, old_pat(16'h5555));
  endtask

  task automatic t_rc;
    run("R9 rc3", pack(1000001, -3, 8, 9, 10, 11, 12, 13), 0, 0, 8'h00, 0, 0, 2'd2, 2'd2, 2'd3,
        4'hF, old_pat(16'h6666));
    run("R9 rc1", pack(1000001, -3, 8, 9, 10, 11, 12, 13), 0, 0, 8'h00, 0, 0, 2'd2, 2'd2, 2'd1,
        4'hF, old_pat(16'h6666));
  endtask

  task automatic t_ud;
    run("R10 vvvv", pack(1, 2, 3, 4, 5, 6, 7, 8), 0, 0, 8'h00, 0, 0, 2'd2, 2'd2, 0, 4'hE,
        old_pat(16'h7777));
    run("R10 enc3", pack(1, 2, 3, 4, 5, 6, 7, 8), 0, 0, 8'h00, 0, 0, 2'd2, 2'd3, 0, 4'hF,
        old_pat(16'h7778));
    run("R10 legacy vvvv", pack(1, 2, 3, 4, 5, 6, 7, 8), 0, 0, 8'h00, 0, 0, 2'd0, 2'd0, 0, 4'h0,
        old_pat(16'h7779));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_corners;
    t_masks;
    t_bcst;
    t_short;
    t_legacy;
    t_rc;
    t_ud;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule